// File: doc/BRIEF.md
# Single-Cycle 16-bit Two-Register Processor Core

This core executes one 16-bit instruction on every clock edge. It keeps two working registers: an address register and a data register. The address register has three jobs. It is the only target of immediate loads. It drives the data-memory address, and the word at that address acts as a third operand. It also supplies the branch target. The data register is the main operand of the arithmetic unit.

An instruction whose top bit is clear loads a 15-bit constant into the address register. An instruction whose top bit is set does several things:
- It computes a result from the data register and one second operand, which is either the address register or the memory word.
- It writes that result to any mix of the address register, the data register and memory.
- It may branch, depending on the sign of the result.

The instruction memory and data memory sit outside the core and are read combinationally in the same cycle. Every edge retires exactly one instruction, so both memory interfaces are plain, with no valid/ready handshake and no back-pressure. The integrator must return the instruction word and the read word within the same cycle.

Top module: `acc16_core`

## Requirements
- R1: An instruction with bit 15 = 0 loads the address register with {1'b0, bits 14:0}, so the loaded value lies between 0 and 32767. It does not assert the memory write strobe.
- R2: `mem_addr_o` always equals the low 15 bits of the address register.
- R3: In a compute instruction (bit 15 = 1), bit 12 selects the second operand: 0 for the address register, 1 for the memory word at the current address. Bits 11:6 are six control bits, from high to low: zero-x, invert-x, zero-y, invert-y, add(1)/AND(0), invert-out. Here x is the data register. The encodings give the following results:
  - Constants: 101010 = 0, 111111 = 1, 111010 = -1.
  - Pass and invert: 001100 = x, 110000 = y, 001101 = ~x, 110001 = ~y.
  - Negate: 001111 = -x, 110011 = -y.
  - Step: 011111 = x+1, 110111 = y+1, 001110 = x-1, 110010 = y-1.
  - Two operands: 000010 = x+y, 010011 = x-y, 000111 = y-x, 000000 = x&y, 010101 = x|y.
- R4: Destination bits act independently: bit 5 writes the address register, bit 4 writes the data register, and bit 3 writes memory. `mem_we_o` is high only for a compute instruction with bit 3 set.
- R5: Branch bits are bit 2 (result < 0), bit 1 (result = 0) and bit 0 (result > 0). The result is compared as a signed value. The branch is taken when any selected condition holds. Code 111 always branches and code 000 never branches.
- R6: When the branch is taken, the program counter loads the address register. Otherwise it advances by one, wrapping from 32767 to 0.
- R7: A memory operand is read at the address register value from before the instruction. For example, loading the address register from memory uses the old address, and the new value appears only after the edge.
- R8: When an instruction both branches and writes the address register, the program counter takes the address register value from before the instruction.
- R9: A synchronous reset forces the program counter to 0. Reset overrides both branching and incrementing. Reset leaves the address and data registers unchanged.
- R10: During a compute instruction, `mem_wr_o` carries the computation result. It stays stable together with the address for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset of the program counter |
| instr_i | input | 16 | Instruction word fetched at `pc_o` |
| pc_o | output | 15 | Program counter, the instruction fetch address |
| mem_rd_i | input | 16 | Data memory word at `mem_addr_o` |
| mem_wr_o | output | 16 | Computation result, the data to store |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_addr_o | output | 15 | Data memory address, taken from the address register |

## Verification
Two pairs of functions can coincide in one cycle, and both pairs are provoked on purpose.

The first pair is a taken branch and a write to the address register. The bench issues an instruction that loads the address register from memory and always branches. It then judges that the program counter lands on the old address, while `mem_addr_o` afterwards shows the freshly read word.

The second pair is reset and a branch that would be taken. The bench holds reset during an always-branch instruction. It expects the counter to go to 0, and it expects the address and data registers to be intact when read back through the ports.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

  localparam int INSTR_W = 16;
  localparam int IMM_W   = INSTR_W - 1;

  // Bit positions of the compute-instruction layout
  localparam int BIT_KIND  = 15;
  localparam int BIT_YSEL  = 12;
  localparam int CTL_HI    = 11;
  localparam int CTL_LO    = 6;
  localparam int BIT_DST_A = 5;
  localparam int BIT_DST_D = 4;
  localparam int BIT_DST_M = 3;
  localparam int BIT_J_LT  = 2;
  localparam int BIT_J_EQ  = 1;
  localparam int BIT_J_GT  = 0;

  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic use_add;
    logic no;
  } alu_ctl_t;

  typedef struct packed {
    logic             is_imm;
    logic [IMM_W-1:0] imm;
    logic             y_mem;
    alu_ctl_t         ctl;
    logic             wr_a;
    logic             wr_d;
    logic             wr_m;
    logic             j_lt;
    logic             j_eq;
    logic             j_gt;
  } dec_t;

endpackage

// File: rtl/acc16_decode.sv
module acc16_decode
  import acc16_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  logic is_cmp;

  always_comb begin
    is_cmp      = instr[BIT_KIND];
    dec.is_imm  = ~is_cmp;
    dec.imm     = instr[IMM_W-1:0];
    dec.y_mem   = instr[BIT_YSEL];
    dec.ctl     = alu_ctl_t'(instr[CTL_HI:CTL_LO]);
    // Destination and branch fields are meaningful only for compute words
    dec.wr_a    = is_cmp & instr[BIT_DST_A];
    dec.wr_d    = is_cmp & instr[BIT_DST_D];
    dec.wr_m    = is_cmp & instr[BIT_DST_M];
    dec.j_lt    = is_cmp & instr[BIT_J_LT];
    dec.j_eq    = is_cmp & instr[BIT_J_EQ];
    dec.j_gt    = is_cmp & instr[BIT_J_GT];
  end

endmodule

// File: rtl/acc16_alu.sv
module acc16_alu
  import acc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  alu_ctl_t     ctl,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);

  logic [W-1:0] xa, xb, ya, yb, core;

  always_comb begin
    xa   = ctl.zx ? '0 : x;
    xb   = ctl.nx ? ~xa : xa;
    ya   = ctl.zy ? '0 : y;
    yb   = ctl.ny ? ~ya : ya;
    core = ctl.use_add ? (xb + yb) : (xb & yb);
    res  = ctl.no ? ~core : core;
  end

  assign is_zero = (res == '0);
  assign is_neg  = res[W-1];

endmodule

// File: rtl/acc16_branch.sv
module acc16_branch (
  input  logic sel_lt,
  input  logic sel_eq,
  input  logic sel_gt,
  input  logic is_zero,
  input  logic is_neg,
  output logic take
);

  logic is_pos;

  always_comb begin
    is_pos = ~is_zero & ~is_neg;
    take   = (sel_lt & is_neg) | (sel_eq & is_zero) | (sel_gt & is_pos);
  end

endmodule

// File: rtl/acc16_core.sv
module acc16_core
  import acc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] instr_i,
  output logic [PC_W-1:0]   pc_o,
  input  logic [DATA_W-1:0] mem_rd_i,
  output logic [DATA_W-1:0] mem_wr_o,
  output logic              mem_we_o,
  output logic [PC_W-1:0]   mem_addr_o
);

  localparam int ADDR_W = DATA_W - 1;

  dec_t              dec;
  logic [DATA_W-1:0] areg_q, dreg_q;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] y_opnd, result;
  logic              res_zero, res_neg, take;

  acc16_decode u_dec (
    .instr (instr_i),
    .dec   (dec)
  );

  // Second operand reads memory at the current (pre-edge) address
  assign y_opnd = dec.y_mem ? mem_rd_i : areg_q;

  acc16_alu #(.W(DATA_W)) u_alu (
    .x       (dreg_q),
    .y       (y_opnd),
    .ctl     (dec.ctl),
    .res     (result),
    .is_zero (res_zero),
    .is_neg  (res_neg)
  );

  acc16_branch u_br (
    .sel_lt  (dec.j_lt),
    .sel_eq  (dec.j_eq),
    .sel_gt  (dec.j_gt),
    .is_zero (res_zero),
    .is_neg  (res_neg),
    .take    (take)
  );

  always_ff @(posedge clk) begin
    if (dec.is_imm)
      areg_q <= {1'b0, dec.imm[ADDR_W-1:0]};
    else if (dec.wr_a)
      areg_q <= result;
    if (dec.wr_d)
      dreg_q <= result;
  end

  // Branch target is the register value before this edge
  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else if (take)
      pc_q <= areg_q[PC_W-1:0];
    else
      pc_q <= pc_q + 1'b1;
  end

  assign pc_o       = pc_q;
  assign mem_addr_o = areg_q[PC_W-1:0];
  assign mem_wr_o   = result;
  assign mem_we_o   = dec.wr_m;

  // R1: immediate word shows up on the address pins one edge later
  a_r1_imm_to_addr: assert property (@(posedge clk) disable iff (rst)
    !instr_i[DATA_W-1] |=> mem_addr_o == $past(instr_i[PC_W-1:0]));

  // R4: strobe only for compute words carrying the memory destination
  a_r4_strobe_qualified: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (instr_i[DATA_W-1] && instr_i[BIT_DST_M]));

  // R5: always-code on a compute word must branch
  a_r5_always_taken: assert property (@(posedge clk) disable iff (rst)
    (instr_i[DATA_W-1] && instr_i[2:0] == 3'b111) |-> take);

  // R5: code 000 never branches
  a_r5_never_taken: assert property (@(posedge clk) disable iff (rst)
    (instr_i[2:0] == 3'b000) |-> !take);

  // R6: sequential advance when not branching
  a_r6_pc_advance: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc_o == $past(pc_o) + 1'b1);

  // R8: branch lands on the pre-edge address register
  a_r8_jump_old_addr: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_o == $past(mem_addr_o));

endmodule

// File: tb/tb_acc16_core.sv
module tb_acc16_core;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr_i;
  logic [14:0] pc_o;
  logic [15:0] mem_rd_i;
  logic [15:0] mem_wr_o;
  logic        mem_we_o;
  logic [14:0] mem_addr_o;

  logic [15:0] ram [0:255];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Values captured mid-cycle by exec
  logic        we_s;
  logic [15:0] wr_s;
  logic [14:0] addr_s;

  always #2.5 clk = ~clk;

  acc16_core dut (
    .clk(clk), .rst(rst), .instr_i(instr_i), .pc_o(pc_o),
    .mem_rd_i(mem_rd_i), .mem_wr_o(mem_wr_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o)
  );

  assign mem_rd_i = ram[mem_addr_o[7:0]];
  always @(posedge clk) if (mem_we_o) ram[mem_addr_o[7:0]] <= mem_wr_o;

  localparam logic [2:0] DA = 3'b100, DD = 3'b010, DM = 3'b001;

  function automatic logic [5:0] ctl_of(int op);
    case (op)
      0: return 6'b101010;  1: return 6'b111111;  2: return 6'b111010;
      3: return 6'b001100;  4: return 6'b110000;  5: return 6'b001101;
      6: return 6'b110001;  7: return 6'b001111;  8: return 6'b110011;
      9: return 6'b011111; 10: return 6'b110111; 11: return 6'b001110;
     12: return 6'b110010; 13: return 6'b000010; 14: return 6'b010011;
     15: return 6'b000111; 16: return 6'b000000; default: return 6'b010101;
    endcase
  endfunction

  function automatic logic [15:0] ref_alu(int op, logic [15:0] d, logic [15:0] y);
    case (op)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
      3: return d;         4: return y;         5: return ~d;
      6: return ~y;        7: return -d;        8: return -y;
      9: return d + 16'd1; 10: return y + 16'd1; 11: return d - 16'd1;
     12: return y - 16'd1; 13: return d + y;    14: return d - y;
     15: return y - d;     16: return d & y;    default: return d | y;
    endcase
  endfunction

  function automatic logic [15:0] cins(logic ym, logic [5:0] c, logic [2:0] dst, logic [2:0] j);
    return {3'b111, ym, c, dst, j};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, capture combinational outputs, cross one rising edge
  task automatic exec(logic [15:0] ins);
    instr_i = ins;
    #1;
    we_s = mem_we_o; wr_s = mem_wr_o; addr_s = mem_addr_o;
    @(negedge clk);
  endtask

  task automatic peek_d(output logic [15:0] d);
    exec(cins(1'b0, ctl_of(3), 3'b000, 3'b000));
    d = wr_s;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    instr_i = cins(1'b0, ctl_of(0), 3'b000, 3'b000);
    repeat (3) @(negedge clk);
    chk(pc_o == 15'd0, "R9 reset pc", pc_o, 0);
    chk(mem_we_o == 1'b0, "R4 no strobe in reset", mem_we_o, 0);
    rst = 1'b0;
  endtask

  task automatic t_imm;
    logic [14:0] pc0;
    pc0 = pc_o;
    exec(16'h7FFF);
    chk(we_s == 1'b0, "R1 no strobe on immediate", we_s, 0);
    chk(mem_addr_o == 15'h7FFF, "R1 R2 immediate max", mem_addr_o, 15'h7FFF);
    chk(pc_o == pc0 + 15'd1, "R6 increment", pc_o, pc0 + 15'd1);
    exec(16'h0005);
    chk(mem_addr_o == 15'h0005, "R1 R2 immediate small", mem_addr_o, 5);
    chk(pc_o == pc0 + 15'd2, "R6 increment again", pc_o, pc0 + 15'd2);
  endtask

  task automatic t_alu;
    ram[5] = 16'h00F0;
    exec(16'h1234);
    exec(cins(1'b0, ctl_of(4), DD, 3'b000));
    exec(16'h0005);
    for (int ym = 0; ym < 2; ym++) begin
      for (int op = 0; op < 18; op++) begin
        logic [15:0] y, e;
        y = ym ? 16'h00F0 : 16'h0005;
        e = ref_alu(op, 16'h1234, y);
        exec(cins(ym[0], ctl_of(op), 3'b000, 3'b000));
        chk(wr_s == e, $sformatf("R3 R10 op%0d ysel%0d", op, ym), wr_s, e);
        chk(we_s == 1'b0, "R4 no strobe without M bit", we_s, 0);
      end
    end
  endtask

  task automatic t_dest;
    logic [15:0] d;
    // D=0x1234, A=5 from t_alu; write D+1 to A, D and memory together
    exec(cins(1'b0, ctl_of(9), DA | DD | DM, 3'b000));
    chk(we_s == 1'b1, "R4 strobe with M bit", we_s, 1);
    chk(addr_s == 15'd5, "R4 R10 store addr is old A", addr_s, 5);
    chk(wr_s == 16'h1235, "R10 store data", wr_s, 16'h1235);
    chk(ram[5] == 16'h1235, "R4 memory written", ram[5], 16'h1235);
    chk(mem_addr_o == 15'h1235, "R4 A written", mem_addr_o, 15'h1235);
    peek_d(d);
    chk(d == 16'h1235, "R4 D written", d, 16'h1235);
    // Memory-only destination leaves A and D alone
    exec(16'h0007);
    exec(cins(1'b0, ctl_of(1), DM, 3'b000));
    chk(ram[7] == 16'h0001, "R4 memory only", ram[7], 1);
    chk(mem_addr_o == 15'd7, "R4 A kept", mem_addr_o, 7);
    peek_d(d);
    chk(d == 16'h1235, "R4 D kept", d, 16'h1235);
  endtask

  task automatic t_jump;
    exec(16'h0100);
    for (int j = 0; j < 8; j++) begin
      for (int v = 0; v < 3; v++) begin
        logic [14:0] pc0, e;
        bit tk;
        pc0 = pc_o;
        tk = (j[2] && v == 2) || (j[1] && v == 0) || (j[0] && v == 1);
        e = tk ? 15'h0100 : pc0 + 15'd1;
        exec(cins(1'b0, ctl_of(v), 3'b000, j[2:0]));
        chk(pc_o == e, $sformatf("R5 R6 code%0d value%0d", j, v), pc_o, e);
      end
    end
  endtask

  task automatic t_wrap;
    exec(16'h7FFF);
    exec(cins(1'b0, ctl_of(0), 3'b000, 3'b111));
    chk(pc_o == 15'h7FFF, "R6 jump to top", pc_o, 15'h7FFF);
    exec(cins(1'b0, ctl_of(0), 3'b000, 3'b000));
    chk(pc_o == 15'd0, "R6 wrap to zero", pc_o, 0);
  endtask

  task automatic t_old_a;
    ram[8'h20] = 16'h0040;
    exec(16'h0020);
    exec(cins(1'b1, ctl_of(4), DA, 3'b111));
    chk(addr_s == 15'h0020, "R7 read at old A", addr_s, 15'h20);
    chk(mem_addr_o == 15'h0040, "R7 A loaded from memory", mem_addr_o, 15'h40);
    chk(pc_o == 15'h0020, "R8 jump uses old A", pc_o, 15'h20);
  endtask

  task automatic t_reset_keep;
    logic [15:0] d;
    // A=0x40 from t_old_a; D=0x1235
    rst = 1'b1;
    exec(cins(1'b0, ctl_of(0), 3'b000, 3'b111));
    rst = 1'b0;
    chk(pc_o == 15'd0, "R9 reset beats jump", pc_o, 0);
    chk(mem_addr_o == 15'h0040, "R9 A kept through reset", mem_addr_o, 15'h40);
    peek_d(d);
    chk(d == 16'h1235, "R9 D kept through reset", d, 16'h1235);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0000;
    rst = 1'b1;
    instr_i = 16'h8000;
    @(negedge clk);
    t_reset();
    t_imm();
    t_alu();
    t_dest();
    t_jump();
    t_wrap();
    t_old_a();
    t_reset_keep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule